// File: doc/BRIEF.md
# Per-Line Trigger Interrupt Controller

This block gathers up to 32 interrupt lines and produces two processor request outputs and one wakeup output. Each line has its own three-bit trigger mode, which selects edge or level sensing. Edge events are held in capture registers until software clears them. Level events follow the input directly. Each line also has a mask bit, a wakeup-enable bit, a routing bit that picks one of the two request outputs, and a source bit. The source bit takes the line either from the external pin or from a software-written test bit, which lets firmware raise an interrupt on any line.

Software reaches the block over a flat single-cycle register bus. Each control register has two word addresses. Writing ones to the even address sets the matching bits. Writing ones to the odd address clears them. Bits written as zero are left as they are, so no read-modify-write is ever needed. Read data is combinational on the address. Every line input, from either source, passes through a two-flop synchronizer before any detection. The request outputs and the wakeup output are registered.

Top module: `trig_irq_ctrl`

## Requirements
- R1: Control registers sit at word-address pairs: trigger bit 0 at 0/1, trigger bit 1 at 2/3, trigger bit 2 at 4/5, source select at 6/7, route at 8/9, wakeup enable at 10/11 and mask at 12/13. A write to the even address ORs the data into the register. Data bits of 0 leave the matching register bits unchanged. Reading either address of a pair returns the register.
- R2: A write to the odd address of a pair clears every register bit whose data bit is 1 and changes no other bit.
- R3: A line whose mode {bit2,bit1,bit0} is 001, 011 or 111 records a 0-to-1 change of its synchronized input in the rising-capture register (word 14). The line's request asserts 4 cycles after the input change. Mode 001 records no falling edge.
- R4: A line in mode 010, 011 or 111 records a 1-to-0 change in the falling-capture register (word 15) and raises its request 4 cycles after the change. Mode 010 records no rising edge.
- R5: Mode 101 makes a line active while its synchronized input is 1. Mode 110 makes it active while the input is 0. Mode 111 adds both levels to both edges. A level-sensed request follows the input 3 cycles later and is not latched.
- R6: Modes 000 and 100 never make a line active and never record an edge.
- R7: A line with route bit 1 drives `irq_req0`. A line with route bit 0 drives `irq_req1`. A change of the route bit moves a pending request 2 cycles after the write.
- R8: A line whose mask bit is 0 drives no request. Setting or clearing the mask bit changes the request 2 cycles after the write.
- R9: `wake_out` is 1 while any active line has its wakeup bit set, whatever its mask. It lags the active state by one register stage.
- R10: A source bit of 1 takes the line from `irq_in`. A source bit of 0 takes it from the test register at word 16, which is written directly and read back. The unselected source has no effect.
- R11: Captured edge bits stay set after the input returns. Writing ones to word 14 or word 15 clears those bits, and the request drops 2 cycles after the write.
- R12: Words 17 and 18 return the masked, active lines routed to request 0 and to request 1. Writes to these words have no effect.
- R13: After reset every register, every capture bit and every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NLINES | External interrupt lines |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| irq_req0 | output | 1 | Processor request 0 |
| irq_req1 | output | 1 | Processor request 1 |
| wake_out | output | 1 | Wakeup request |

## Verification
Each stimulus is applied at a falling edge, and its result is due a fixed number of rising edges later. An edge-sensed request is due after four edges: two synchronizer stages, the capture register and the status register. A level-sensed request is due after three. A write to a mask, route or clear address shows at the request pins after two edges. A write to the test register adds the two synchronizer stages. The driver pushes each expected value with its due cycle into a queue. A monitor samples a quarter period after each rising edge and pops the entries that are due. Where a check expects no change, a quiet value is also queued one cycle before the due cycle, so an early response counts as a failure as well.

// File: rtl/trig_irq_pkg.sv
package trig_irq_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;

    // control register slots, each owning a set/clear word pair
    localparam int NCTL      = 7;
    localparam int CTL_CFG0  = 0;
    localparam int CTL_CFG1  = 1;
    localparam int CTL_CFG2  = 2;
    localparam int CTL_SRC   = 3;
    localparam int CTL_ROUTE = 4;
    localparam int CTL_WAKE  = 5;
    localparam int CTL_MASK  = 6;

    localparam logic [ADDR_W-1:0] A_RISE  = 5'd14;
    localparam logic [ADDR_W-1:0] A_FALL  = 5'd15;
    localparam logic [ADDR_W-1:0] A_TEST  = 5'd16;
    localparam logic [ADDR_W-1:0] A_STAT0 = 5'd17;
    localparam logic [ADDR_W-1:0] A_STAT1 = 5'd18;

    typedef struct packed {
        logic rise;
        logic fall;
        logic high;
        logic low;
    } trig_sel_t;

    function automatic logic [ADDR_W-1:0] set_addr(input int idx);
        return ADDR_W'(2 * idx);
    endfunction

    function automatic logic [ADDR_W-1:0] clr_addr(input int idx);
        return ADDR_W'(2 * idx + 1);
    endfunction

    // mode word is {bit2, bit1, bit0}
    function automatic trig_sel_t decode_mode(input logic [2:0] m);
        trig_sel_t s;
        s = '0;
        case (m)
            3'b001: s.rise = 1'b1;
            3'b010: s.fall = 1'b1;
            3'b011: begin s.rise = 1'b1; s.fall = 1'b1; end
            3'b101: s.high = 1'b1;
            3'b110: s.low  = 1'b1;
            3'b111: s = '1;
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/trig_irq_regs.sv
module trig_irq_regs
    import trig_irq_pkg::*;
#(
    parameter int NLINES = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [NLINES-1:0]               wr_bits,
    output logic [NCTL-1:0][NLINES-1:0]     ctl,
    output logic [NLINES-1:0]               test_bits
);

    typedef struct packed {
        logic [NCTL-1:0][NLINES-1:0] ctl;
        logic [NLINES-1:0]           test;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            for (int i = 0; i < NCTL; i++) begin
                if (wr_addr == set_addr(i)) begin
                    r_d.ctl[i] = r_q.ctl[i] | wr_bits;
                end else if (wr_addr == clr_addr(i)) begin
                    r_d.ctl[i] = r_q.ctl[i] & ~wr_bits;
                end
            end
            if (wr_addr == A_TEST) begin
                r_d.test = wr_bits;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctl       = r_q.ctl;
    assign test_bits = r_q.test;

endmodule

// File: rtl/trig_irq_detect.sv
module trig_irq_detect
    import trig_irq_pkg::*;
#(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_in,
    input  logic [NLINES-1:0] test_bits,
    input  logic [NLINES-1:0] src_sel,
    input  logic [NLINES-1:0] cfg0,
    input  logic [NLINES-1:0] cfg1,
    input  logic [NLINES-1:0] cfg2,
    input  logic [NLINES-1:0] rise_clr,
    input  logic [NLINES-1:0] fall_clr,
    output logic [NLINES-1:0] active,
    output logic [NLINES-1:0] rise_cap,
    output logic [NLINES-1:0] fall_cap
);

    logic [NLINES-1:0] en_rise, en_fall, en_high, en_low;

    for (genvar g = 0; g < NLINES; g++) begin : g_mode
        trig_sel_t sel;
        assign sel        = decode_mode({cfg2[g], cfg1[g], cfg0[g]});
        assign en_rise[g] = sel.rise;
        assign en_fall[g] = sel.fall;
        assign en_high[g] = sel.high;
        assign en_low[g]  = sel.low;
    end

    typedef struct packed {
        logic [NLINES-1:0] sync1;
        logic [NLINES-1:0] sync2;
        logic [NLINES-1:0] prev;
        logic [NLINES-1:0] rise;
        logic [NLINES-1:0] fall;
    } det_t;

    det_t d_d, d_q;

    always_comb begin
        d_d       = d_q;
        d_d.sync1 = (src_sel & irq_in) | (~src_sel & test_bits);
        d_d.sync2 = d_q.sync1;
        d_d.prev  = d_q.sync2;
        // a new edge wins over a clear in the same cycle
        d_d.rise  = (d_q.rise & ~rise_clr) | (d_q.sync2 & ~d_q.prev & en_rise);
        d_d.fall  = (d_q.fall & ~fall_clr) | (~d_q.sync2 & d_q.prev & en_fall);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign active   = (d_q.rise & en_rise) | (d_q.fall & en_fall)
                    | (d_q.sync2 & en_high) | (~d_q.sync2 & en_low);
    assign rise_cap = d_q.rise;
    assign fall_cap = d_q.fall;

endmodule

// File: rtl/trig_irq_ctrl.sv
module trig_irq_ctrl
    import trig_irq_pkg::*;
#(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_in,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [4:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_req0,
    output logic              irq_req1,
    output logic              wake_out
);

    logic                        wr_en;
    logic [NLINES-1:0]           wr_bits;
    logic [NCTL-1:0][NLINES-1:0] ctl;
    logic [NLINES-1:0]           test_bits;
    logic [NLINES-1:0]           mask_vec, wake_vec, route_vec;
    logic [NLINES-1:0]           rise_clr, fall_clr;
    logic [NLINES-1:0]           active, rise_vec, fall_vec;

    assign wr_en     = bus_en & bus_we;
    assign wr_bits   = bus_wdata[NLINES-1:0];
    assign mask_vec  = ctl[CTL_MASK];
    assign wake_vec  = ctl[CTL_WAKE];
    assign route_vec = ctl[CTL_ROUTE];
    assign rise_clr  = (wr_en && bus_addr == A_RISE) ? wr_bits : '0;
    assign fall_clr  = (wr_en && bus_addr == A_FALL) ? wr_bits : '0;

    trig_irq_regs #(.NLINES(NLINES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (bus_addr),
        .wr_bits   (wr_bits),
        .ctl       (ctl),
        .test_bits (test_bits)
    );

    trig_irq_detect #(.NLINES(NLINES)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .test_bits (test_bits),
        .src_sel   (ctl[CTL_SRC]),
        .cfg0      (ctl[CTL_CFG0]),
        .cfg1      (ctl[CTL_CFG1]),
        .cfg2      (ctl[CTL_CFG2]),
        .rise_clr  (rise_clr),
        .fall_clr  (fall_clr),
        .active    (active),
        .rise_cap  (rise_vec),
        .fall_cap  (fall_vec)
    );

    typedef struct packed {
        logic [NLINES-1:0] stat0;
        logic [NLINES-1:0] stat1;
        logic              wake;
    } out_t;

    out_t o_d, o_q;
    logic [NLINES-1:0] pend;

    always_comb begin
        pend       = active & mask_vec;
        o_d        = o_q;
        o_d.stat0  = pend & route_vec;
        o_d.stat1  = pend & ~route_vec;
        o_d.wake   = |(active & wake_vec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign irq_req0 = |o_q.stat0;
    assign irq_req1 = |o_q.stat1;
    assign wake_out = o_q.wake;

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCTL; i++) begin
            if (bus_addr == set_addr(i) || bus_addr == clr_addr(i)) begin
                bus_rdata[NLINES-1:0] = ctl[i];
            end
        end
        case (bus_addr)
            A_RISE:  bus_rdata[NLINES-1:0] = rise_vec;
            A_FALL:  bus_rdata[NLINES-1:0] = fall_vec;
            A_TEST:  bus_rdata[NLINES-1:0] = test_bits;
            A_STAT0: bus_rdata[NLINES-1:0] = o_q.stat0;
            A_STAT1: bus_rdata[NLINES-1:0] = o_q.stat1;
            default: ;
        endcase
    end

endmodule

// File: rtl/trig_irq_ctrl_chk.sv
module trig_irq_ctrl_chk
    import trig_irq_pkg::*;
#(
    parameter int NLINES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [4:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [NLINES-1:0] mask_vec,
    input logic [NLINES-1:0] wake_vec,
    input logic [NLINES-1:0] rise_vec,
    input logic              irq_req0,
    input logic              irq_req1,
    input logic              wake_out
);

    localparam logic [4:0] A_MASK_SET = 5'd12;
    localparam logic [4:0] A_MASK_CLR = 5'd13;

    p_set_alias_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == A_MASK_SET)
        |=> ((mask_vec & $past(bus_wdata[NLINES-1:0])) == $past(bus_wdata[NLINES-1:0])));

    p_clr_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == A_MASK_CLR)
        |=> ((mask_vec & $past(bus_wdata[NLINES-1:0])) == '0));

    p_capture_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && bus_we && bus_addr == A_RISE)
        |=> ((rise_vec & $past(rise_vec)) == $past(rise_vec)));

    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_vec == '0) |=> (!irq_req0 && !irq_req1));

    p_wake_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_vec == '0) |=> !wake_out);

endmodule

bind trig_irq_ctrl trig_irq_ctrl_chk #(.NLINES(NLINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .mask_vec  (mask_vec),
    .wake_vec  (wake_vec),
    .rise_vec  (rise_vec),
    .irq_req0  (irq_req0),
    .irq_req1  (irq_req1),
    .wake_out  (wake_out)
);

// File: tb/trig_irq_ctrl_tb.sv
module trig_irq_ctrl_tb;

    localparam int NL = 32;
    localparam logic [4:0] CFG0_S = 5'd0, CFG1_S = 5'd2, CFG2_S = 5'd4;
    localparam logic [4:0] SRC_S = 5'd6, SRC_C = 5'd7, ROUTE_S = 5'd8, ROUTE_C = 5'd9;
    localparam logic [4:0] WAKE_S = 5'd10, WAKE_C = 5'd11, MASK_S = 5'd12, MASK_C = 5'd13;
    localparam logic [4:0] RISE = 5'd14, FALL = 5'd15, TEST = 5'd16, STAT0 = 5'd17, STAT1 = 5'd18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] irq_in = '0;
    logic          bus_en = 1'b0, bus_we = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_req0, irq_req1, wake_out;

    always #10 clk = ~clk;

    trig_irq_ctrl #(.NLINES(NL)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req0(irq_req0), .irq_req1(irq_req1), .wake_out(wake_out)
    );

    typedef struct {
        int          due;
        bit          is_rd;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    int    k = 0;
    bit    done = 0;

    function automatic void push(int due, bit is_rd, logic [31:0] exp, string tag);
        item_t it;
        int pos;
        it.due = due; it.is_rd = is_rd; it.exp = exp; it.tag = tag;
        pos = q.size();
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].due > due) begin pos = i; break; end
        end
        q.insert(pos, it);
    endfunction

    // outputs packed as {wake_out, irq_req1, irq_req0}
    function automatic void exp_out(int due, logic [2:0] v, string tag);
        push(due, 1'b0, {29'd0, v}, tag);
    endfunction

    // monitor: a quarter period after each rising edge
    initial begin
        forever begin
            item_t it;
            logic [31:0] obs;
            @(posedge clk);
            #5;
            cyc++;
            while (q.size() > 0 && q[0].due <= cyc) begin
                it  = q.pop_front();
                obs = it.is_rd ? bus_rdata : {29'd0, wake_out, irq_req1, irq_req0};
                checks++;
                if (obs !== it.exp) begin
                    errors++;
                    $display("FAIL %s cycle %0d: got %h expected %h", it.tag, cyc, obs, it.exp);
                end
            end
        end
    end

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            bus_en = 1'b0; bus_we = 1'b0;
        end
        k = cyc;
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        k = cyc;
    endtask

    task automatic rd(logic [4:0] a, logic [31:0] e, string tag);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        k = cyc;
        push(k + 1, 1'b1, e, tag);
    endtask

    task automatic drive(int line, bit v);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        irq_in[line] = v;
        k = cyc;
    endtask

    task automatic quiesce();
        wr(MASK_C, 32'hFFFF_FFFF);
        wr(WAKE_C, 32'hFFFF_FFFF);
        wr(RISE, 32'hFFFF_FFFF);
        wr(FALL, 32'hFFFF_FFFF);
        idle(4);
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R13 reset state
        exp_out(k + 1, 3'b000, "R13");
        rd(CFG0_S, 32'h0, "R13");
        rd(MASK_S, 32'h0, "R13");
        rd(ROUTE_C, 32'h0, "R13");
        rd(RISE, 32'h0, "R13");

        // R1 / R2 set and clear aliases on the source register
        wr(SRC_S, 32'h0000_00FF);
        rd(SRC_S, 32'h0000_00FF, "R1");
        rd(SRC_C, 32'h0000_00FF, "R1");
        wr(SRC_S, 32'h0000_0F00);
        rd(SRC_S, 32'h0000_0FFF, "R1");
        wr(SRC_C, 32'h0000_000F);
        rd(SRC_S, 32'h0000_0FF0, "R2");
        wr(SRC_S, 32'hFFFF_FFFF);
        idle(2);

        // R3 rising edge, line 0 on request 0
        wr(CFG0_S, 32'h1); wr(ROUTE_S, 32'h1); wr(MASK_S, 32'h1);
        idle(3);
        drive(0, 1'b1);
        exp_out(k + 3, 3'b000, "R3");
        exp_out(k + 4, 3'b001, "R3");
        idle(6);
        drive(0, 1'b0);
        exp_out(k + 6, 3'b001, "R11");
        idle(7);
        rd(RISE, 32'h1, "R3");
        rd(FALL, 32'h0, "R3");
        wr(RISE, 32'h1);
        exp_out(k + 1, 3'b001, "R11");
        exp_out(k + 2, 3'b000, "R11");
        idle(3);
        quiesce();

        // R4 falling edge, line 1 on request 1
        wr(CFG1_S, 32'h2); wr(MASK_S, 32'h2);
        idle(2);
        drive(1, 1'b1);
        exp_out(k + 6, 3'b000, "R4");
        idle(7);
        drive(1, 1'b0);
        exp_out(k + 3, 3'b000, "R4");
        exp_out(k + 4, 3'b010, "R4");
        idle(6);
        rd(FALL, 32'h2, "R4");
        rd(RISE, 32'h0, "R4");
        wr(FALL, 32'h2);
        exp_out(k + 2, 3'b000, "R11");
        idle(3);
        quiesce();

        // both edges, line 2 on request 0
        wr(CFG0_S, 32'h4); wr(CFG1_S, 32'h4); wr(ROUTE_S, 32'h4); wr(MASK_S, 32'h4);
        idle(2);
        drive(2, 1'b1);
        exp_out(k + 4, 3'b001, "R3");
        idle(6);
        wr(RISE, 32'h4);
        exp_out(k + 2, 3'b000, "R11");
        idle(4);
        drive(2, 1'b0);
        exp_out(k + 3, 3'b000, "R4");
        exp_out(k + 4, 3'b001, "R4");
        idle(6);
        rd(FALL, 32'h4, "R4");
        quiesce();

        // R5 high level, line 3 on request 0
        wr(CFG0_S, 32'h8); wr(CFG2_S, 32'h8); wr(ROUTE_S, 32'h8); wr(MASK_S, 32'h8);
        idle(3);
        drive(3, 1'b1);
        exp_out(k + 2, 3'b000, "R5");
        exp_out(k + 3, 3'b001, "R5");
        idle(5);
        rd(RISE, 32'h0, "R5");
        drive(3, 1'b0);
        exp_out(k + 2, 3'b001, "R5");
        exp_out(k + 3, 3'b000, "R5");
        idle(5);
        quiesce();

        // R5 low level, line 4 on request 1
        wr(CFG1_S, 32'h10); wr(CFG2_S, 32'h10);
        idle(2);
        wr(MASK_S, 32'h10);
        exp_out(k + 1, 3'b000, "R5");
        exp_out(k + 2, 3'b010, "R5");
        idle(3);
        drive(4, 1'b1);
        exp_out(k + 2, 3'b010, "R5");
        exp_out(k + 3, 3'b000, "R5");
        idle(5);
        quiesce();

        // R5 mode 111 on line 8, request 1
        wr(CFG0_S, 32'h100); wr(CFG1_S, 32'h100); wr(CFG2_S, 32'h100);
        idle(2);
        wr(MASK_S, 32'h100);
        exp_out(k + 2, 3'b010, "R5");
        idle(3);
        drive(8, 1'b1);
        exp_out(k + 6, 3'b010, "R5");
        idle(7);
        quiesce();

        // R6 disabled modes: line 5 mode 100, line 6 mode 000
        wr(CFG2_S, 32'h20); wr(ROUTE_S, 32'h20); wr(MASK_S, 32'h60);
        idle(2);
        drive(5, 1'b1);
        irq_in[6] = 1'b1;
        exp_out(k + 5, 3'b000, "R6");
        idle(6);
        drive(5, 1'b0);
        irq_in[6] = 1'b0;
        exp_out(k + 5, 3'b000, "R6");
        idle(6);
        rd(RISE, 32'h0, "R6");
        rd(FALL, 32'h0, "R6");
        quiesce();

        // R8 mask on line 3 (high level, request 0)
        drive(3, 1'b1);
        exp_out(k + 5, 3'b000, "R8");
        idle(6);
        wr(MASK_S, 32'h8);
        exp_out(k + 1, 3'b000, "R8");
        exp_out(k + 2, 3'b001, "R8");
        idle(3);
        wr(MASK_C, 32'h8);
        exp_out(k + 2, 3'b000, "R8");
        idle(3);

        // R9 wakeup without mask
        wr(WAKE_S, 32'h8);
        exp_out(k + 2, 3'b100, "R9");
        idle(3);
        drive(3, 1'b0);
        exp_out(k + 2, 3'b100, "R9");
        exp_out(k + 3, 3'b000, "R9");
        idle(4);
        wr(WAKE_C, 32'h8);
        idle(2);

        // R7 routing move
        drive(3, 1'b1);
        wr(MASK_S, 32'h8);
        exp_out(k + 2, 3'b001, "R7");
        idle(3);
        wr(ROUTE_C, 32'h8);
        exp_out(k + 1, 3'b001, "R7");
        exp_out(k + 2, 3'b010, "R7");
        idle(3);

        // R12 status words, read only
        rd(STAT1, 32'h8, "R12");
        rd(STAT0, 32'h0, "R12");
        wr(STAT0, 32'hFFFF_FFFF);
        wr(STAT1, 32'h0);
        idle(2);
        rd(STAT0, 32'h0, "R12");
        rd(STAT1, 32'h8, "R12");
        exp_out(k + 1, 3'b010, "R12");
        idle(1);
        quiesce();
        drive(3, 1'b0);
        idle(4);

        // R10 source select on line 7 (high level, request 0)
        wr(CFG0_S, 32'h80); wr(CFG2_S, 32'h80); wr(ROUTE_S, 32'h80);
        wr(SRC_C, 32'h80); wr(MASK_S, 32'h80);
        idle(3);
        drive(7, 1'b1);
        exp_out(k + 5, 3'b000, "R10");
        idle(6);
        wr(TEST, 32'h80);
        exp_out(k + 3, 3'b000, "R10");
        exp_out(k + 4, 3'b001, "R10");
        idle(5);
        rd(TEST, 32'h80, "R10");
        wr(TEST, 32'h0);
        exp_out(k + 3, 3'b001, "R10");
        exp_out(k + 4, 3'b000, "R10");
        idle(6);

        wait (q.size() == 0);
        idle(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule